// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Test Unit

This unit carries out the second byte of the bit-manipulation prefix of an 8-bit CPU. Each accepted opcode byte picks one of two groups of work. The first group holds eight shift and rotate operations, and the second is a test of one bit. The opcode also picks the operand. That operand is one of seven byte registers or the memory byte addressed by the HL pair. The surrounding core supplies the operand byte and the incoming carry. One clock later the unit returns the result byte, the place the result goes back to, the new flag byte and the T-state count the instruction costs.

The unit also keeps the memory refresh register. Each accepted prefixed byte counts as one opcode fetch, so the low seven bits of that register advance by one and bit 7 keeps its value. The core can load the register directly. Opcodes from 80h upward (bit set and bit reset) do not belong to this unit. They still count as a fetch, but they produce no result.

Top module: `srb_unit`

## Requirements
- R1: On every result, wb_sel_o equals opcode bits [2:0], with codes 0..7 standing for B, C, D, E, H, L, memory at HL, A. wb_mem_o is 1 exactly when that code is 6.
- R2: For opcodes 00h..3Fh, opcode bits [5:3] select the operation: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic shift left (0 in), 5 arithmetic shift right (bit 7 kept), 6 shift left with 1 inserted into bit 0, 7 logical shift right (0 in). The bit shifted out becomes the carry flag.
- R3: The flag byte has the layout S=7, Z=6, H=4, P/V=2, N=1, C=0, and bits 5 and 3 are 0. After a shift or rotate, S is bit 7 of the result and Z is set when the result is zero. P/V is 1 when the result has an even number of ones. H and N are 0.
- R4: For opcodes 40h..7Fh the unit tests bit opcode[5:3] of the operand. Z (and P/V) is 1 when that bit is 0. S is 1 only when the tested bit is bit 7 and it is set. H is 1, N is 0 and C equals carry_i. result_o equals the operand unchanged.
- R5: tstates_o is 8 for any register operand. It is 15 for a shift or rotate on memory and 12 for a bit test on memory.
- R6: wb_en_o is 1 for shifts and rotates, which write to the register or the memory byte given by R1. It is 0 for bit tests.
- R7: Every cycle with valid_i high, the low seven bits of r_o increment modulo 128 and bit 7 is kept. r_wr_i loads r_wdata_i and takes priority over the increment.
- R8: An opcode with bit 7 set does not raise valid_o, but it still advances R as in R7.
- R9: Results appear one clock after valid_i. After reset all outputs are 0, and valid_o stays 0 in cycles without valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A prefixed opcode byte is presented |
| opcode_i | input | 8 | Second opcode byte |
| operand_i | input | 8 | Selected register or memory byte |
| carry_i | input | 1 | Incoming carry flag |
| r_wr_i | input | 1 | Load the refresh register |
| r_wdata_i | input | 8 | Value to load into the refresh register |
| valid_o | output | 1 | A result is present |
| result_o | output | 8 | Result byte |
| wb_sel_o | output | 3 | Write-back operand code |
| wb_mem_o | output | 1 | The operand is memory at HL |
| wb_en_o | output | 1 | The result must be written back |
| flags_o | output | 8 | New flag byte |
| tstates_o | output | 4 | T-states the instruction takes |
| r_o | output | 8 | Refresh register |

## Verification
The bench applies every opcode from 00h to 7Fh to all 256 operand values, with the incoming carry both clear and set. This full sweep separates the two rotates that go through carry from the circular rotates. It also separates the shift that inserts 1 from the arithmetic left shift, and it exercises the parity, zero and sign flags on every possible result. Sweeping the bit-test group over all operands and indices shows that the right bit is tested, that the carry passes through unchanged and that nothing is written back. Separate runs with the refresh register loaded near its seven-bit wrap point and with the upper opcode range check that bit 7 is kept and that out-of-range opcodes give no result but still count as a fetch.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

  localparam int unsigned F_S  = 7;
  localparam int unsigned F_Z  = 6;
  localparam int unsigned F_H  = 4;
  localparam int unsigned F_PV = 2;
  localparam int unsigned F_N  = 1;
  localparam int unsigned F_C  = 0;

  typedef enum logic [2:0] {
    SH_RLC = 3'd0,
    SH_RRC = 3'd1,
    SH_RL  = 3'd2,
    SH_RR  = 3'd3,
    SH_SLA = 3'd4,
    SH_SRA = 3'd5,
    SH_SLL = 3'd6,
    SH_SRL = 3'd7
  } shift_op_e;
endpackage

// File: rtl/srb_shift_unit.sv
module srb_shift_unit
  import srb_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  shift_op_e         op_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              cout_o
);
  localparam int unsigned MSB = BYTE_W - 1;

  always_comb begin
    // left-moving ops lose the MSB, right-moving ops lose the LSB
    cout_o = op_i[0] ? a_i[0] : a_i[MSB];
    unique case (op_i)
      SH_RLC:  res_o = {a_i[MSB-1:0], a_i[MSB]};
      SH_RRC:  res_o = {a_i[0], a_i[MSB:1]};
      SH_RL:   res_o = {a_i[MSB-1:0], cin_i};
      SH_RR:   res_o = {cin_i, a_i[MSB:1]};
      SH_SLA:  res_o = {a_i[MSB-1:0], 1'b0};
      SH_SRA:  res_o = {a_i[MSB], a_i[MSB:1]};
      SH_SLL:  res_o = {a_i[MSB-1:0], 1'b1};
      default: res_o = {1'b0, a_i[MSB:1]};
    endcase
  end
endmodule

// File: rtl/srb_bit_test.sv
module srb_bit_test
  import srb_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [SEL_W-1:0]  idx_i,
  output logic              zero_o,
  output logic              sign_o
);
  logic [BYTE_W-1:0] hit;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_sel
    assign hit[g] = (idx_i == SEL_W'(g)) & a_i[g];
  end

  assign zero_o = ~|hit;
  assign sign_o = hit[BYTE_W-1];
endmodule

// File: rtl/srb_refresh.sv
module srb_refresh
  import srb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bump_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] r_o
);
  localparam int unsigned CNT_W = BYTE_W - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_o <= '0;
    else if (wr_i)   r_o <= wdata_i;
    else if (bump_i) r_o <= {r_o[BYTE_W-1], r_o[CNT_W-1:0] + CNT_W'(1)};
  end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
  import srb_pkg::*;
#(
  parameter int unsigned T_REG     = 8,
  parameter int unsigned T_MEM_ROT = 15,
  parameter int unsigned T_MEM_BIT = 12,
  localparam int unsigned T_MAX = (T_MEM_ROT > T_MEM_BIT)
                                  ? ((T_MEM_ROT > T_REG) ? T_MEM_ROT : T_REG)
                                  : ((T_MEM_BIT > T_REG) ? T_MEM_BIT : T_REG),
  localparam int unsigned TS_W  = $clog2(T_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        operand_i,
  input  logic              carry_i,
  input  logic              r_wr_i,
  input  logic [7:0]        r_wdata_i,
  output logic              valid_o,
  output logic [7:0]        result_o,
  output logic [2:0]        wb_sel_o,
  output logic              wb_mem_o,
  output logic              wb_en_o,
  output logic [7:0]        flags_o,
  output logic [TS_W-1:0]   tstates_o,
  output logic [7:0]        r_o
);
  logic              in_range, is_bit, is_mem;
  logic [SEL_W-1:0]  sel, fld;
  logic [BYTE_W-1:0] sh_res;
  logic              sh_cout, bt_zero, bt_sign;
  logic [BYTE_W-1:0] nx_res, nx_flags;
  logic [TS_W-1:0]   nx_ts;

  assign in_range = ~opcode_i[7];
  assign is_bit   = opcode_i[6];
  assign fld      = opcode_i[5:3];
  assign sel      = opcode_i[2:0];
  assign is_mem   = (sel == SEL_MEM);

  srb_shift_unit u_shift (
    .a_i   (operand_i),
    .op_i  (shift_op_e'(fld)),
    .cin_i (carry_i),
    .res_o (sh_res),
    .cout_o(sh_cout)
  );

  srb_bit_test u_bit (
    .a_i   (operand_i),
    .idx_i (fld),
    .zero_o(bt_zero),
    .sign_o(bt_sign)
  );

  srb_refresh u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bump_i (valid_i),
    .wr_i   (r_wr_i),
    .wdata_i(r_wdata_i),
    .r_o    (r_o)
  );

  always_comb begin
    nx_flags = '0;
    if (is_bit) begin
      nx_res         = operand_i;
      nx_flags[F_S]  = bt_sign;
      nx_flags[F_Z]  = bt_zero;
      nx_flags[F_H]  = 1'b1;
      nx_flags[F_PV] = bt_zero;
      nx_flags[F_C]  = carry_i;
      nx_ts          = is_mem ? TS_W'(T_MEM_BIT) : TS_W'(T_REG);
    end else begin
      nx_res         = sh_res;
      nx_flags[F_S]  = sh_res[BYTE_W-1];
      nx_flags[F_Z]  = ~|sh_res;
      nx_flags[F_PV] = ~^sh_res;
      nx_flags[F_C]  = sh_cout;
      nx_ts          = is_mem ? TS_W'(T_MEM_ROT) : TS_W'(T_REG);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      wb_sel_o  <= '0;
      wb_mem_o  <= 1'b0;
      wb_en_o   <= 1'b0;
      flags_o   <= '0;
      tstates_o <= '0;
    end else begin
      valid_o <= valid_i & in_range;
      if (valid_i & in_range) begin
        result_o  <= nx_res;
        wb_sel_o  <= sel;
        wb_mem_o  <= is_mem;
        wb_en_o   <= ~is_bit;
        flags_o   <= nx_flags;
        tstates_o <= nx_ts;
      end
    end
  end
endmodule

// File: rtl/srb_unit_chk.sv
module srb_unit_chk #(
  parameter int unsigned TS_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [7:0]      opcode_i,
  input logic            carry_i,
  input logic            r_wr_i,
  input logic            valid_o,
  input logic [2:0]      wb_sel_o,
  input logic            wb_mem_o,
  input logic            wb_en_o,
  input logic [7:0]      flags_o,
  input logic [TS_W-1:0] tstates_o,
  input logic [7:0]      r_o
);
  assert_sel_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (wb_sel_o == $past(opcode_i[2:0])) && (wb_mem_o == (wb_sel_o == 3'd6)));

  assert_h_only_on_test_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flags_o[4] == $past(opcode_i[6]));

  assert_test_keeps_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(opcode_i[6])) |-> flags_o[0] == $past(carry_i));

  assert_tstate_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (tstates_o == TS_W'(8) || tstates_o == TS_W'(12) || tstates_o == TS_W'(15)));

  assert_no_wb_on_test_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> wb_en_o == !$past(opcode_i[6]));

  assert_r_top_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(r_wr_i) |-> r_o[7] == $past(r_o[7]));

  assert_upper_range_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i) && !$past(opcode_i[7]));

  assert_idle_no_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

bind srb_unit srb_unit_chk #(.TS_W(TS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .opcode_i (opcode_i),
  .carry_i  (carry_i),
  .r_wr_i   (r_wr_i),
  .valid_o  (valid_o),
  .wb_sel_o (wb_sel_o),
  .wb_mem_o (wb_mem_o),
  .wb_en_o  (wb_en_o),
  .flags_o  (flags_o),
  .tstates_o(tstates_o),
  .r_o      (r_o)
);

// File: tb/srb_unit_tb.sv
module srb_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       valid_i = 1'b0, carry_i = 1'b0, r_wr_i = 1'b0;
  logic [7:0] opcode_i = '0, operand_i = '0, r_wdata_i = '0;
  logic       valid_o, wb_mem_o, wb_en_o;
  logic [7:0] result_o, flags_o, r_o;
  logic [2:0] wb_sel_o;
  logic [3:0] tstates_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] r_exp = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srb_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
    .operand_i(operand_i), .carry_i(carry_i), .r_wr_i(r_wr_i), .r_wdata_i(r_wdata_i),
    .valid_o(valid_o), .result_o(result_o), .wb_sel_o(wb_sel_o), .wb_mem_o(wb_mem_o),
    .wb_en_o(wb_en_o), .flags_o(flags_o), .tstates_o(tstates_o), .r_o(r_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail < 40) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [8:0] model_shift(input int k, input logic [7:0] a, input logic c);
    int v = int'(a);
    int r; logic co;
    case (k)
      0: begin r = ((v * 2) % 256) + v / 128; co = a[7]; end
      1: begin r = v / 2 + (v % 2) * 128;     co = a[0]; end
      2: begin r = ((v * 2) % 256) + int'(c); co = a[7]; end
      3: begin r = v / 2 + int'(c) * 128;     co = a[0]; end
      4: begin r = (v * 2) % 256;             co = a[7]; end
      5: begin r = v / 2 + (v / 128) * 128;   co = a[0]; end
      6: begin r = (v * 2) % 256 + 1;         co = a[7]; end
      default: begin r = v / 2;               co = a[0]; end
    endcase
    return {co, 8'(r)};
  endfunction

  task automatic step(input logic [7:0] op, input logic [7:0] a, input logic c);
    opcode_i = op; operand_i = a; carry_i = c; valid_i = 1'b1;
    r_exp = {r_exp[7], 7'((r_exp[6:0] + 7'd1))};
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic check_op(input logic [7:0] op, input logic [7:0] a, input logic c);
    int k = int'(op[5:3]);
    logic mem = (op[2:0] == 3'd6);
    logic [7:0] res_e, fl_e;
    logic [8:0] sh;
    logic [3:0] ts_e;
    step(op, a, c);
    check("R9 valid", 32'(valid_o), 32'd1);
    check("R1 target", {wb_mem_o, wb_sel_o}, {mem, op[2:0]});
    if (!op[6]) begin
      sh = model_shift(k, a, c);
      res_e = sh[7:0];
      fl_e = {res_e[7], res_e == 8'd0, 1'b0, 1'b0, 1'b0, (ones(res_e) % 2) == 0, 1'b0, sh[8]};
      ts_e = mem ? 4'd15 : 4'd8;
      check("R2 result", result_o, res_e);
      check("R3 flags", flags_o, fl_e);
      check("R6 write-back", 32'(wb_en_o), 32'd1);
    end else begin
      logic z = ((int'(a) >> k) % 2) == 0;
      fl_e = {(k == 7) && !z, z, 1'b0, 1'b1, 1'b0, z, 1'b0, c};
      ts_e = mem ? 4'd12 : 4'd8;
      check("R4 result", result_o, a);
      check("R4 flags", flags_o, fl_e);
      check("R6 no write-back", 32'(wb_en_o), 32'd0);
    end
    check("R5 tstates", tstates_o, ts_e);
    check("R7 refresh", r_o, r_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check("R9 reset valid", 32'(valid_o), 32'd0);
    check("R9 reset outputs", {result_o, flags_o, tstates_o, wb_en_o, r_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 idle valid", 32'(valid_o), 32'd0);
    check("R7 idle refresh", r_o, 8'd0);

    for (int op = 0; op < 128; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          check_op(8'(op), 8'(a), 1'(c));

    // R7: load near wrap point with bit 7 set
    r_wr_i = 1'b1; r_wdata_i = 8'hFE;
    @(negedge clk);
    r_wr_i = 1'b0; r_exp = 8'hFE;
    check("R7 load", r_o, 8'hFE);
    check_op(8'h06, 8'h81, 1'b0);
    check("R7 at FF", r_o, 8'hFF);
    check_op(8'h46, 8'h01, 1'b1);
    check("R7 wrap keeps bit7", r_o, 8'h80);
    // R7: load beats increment
    r_wr_i = 1'b1; r_wdata_i = 8'h7F; valid_i = 1'b1; opcode_i = 8'h00;
    @(negedge clk);
    r_wr_i = 1'b0; valid_i = 1'b0; r_exp = 8'h7F;
    check("R7 load priority", r_o, 8'h7F);
    check_op(8'h38, 8'h02, 1'b1);
    check("R7 wrap bit7 clear", r_o, 8'h00);

    for (int op = 128; op < 256; op++) begin
      step(8'(op), 8'(op), 1'b1);
      check("R8 no result", 32'(valid_o), 32'd0);
      check("R8 refresh bump", r_o, r_exp);
    end
    @(negedge clk);
    check("R9 idle after run", 32'(valid_o), 32'd0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule